// File: doc/BRIEF.md
# Memory Pattern Fill-and-Verify Engine

This block is a hardware test sequencer for a word-wide memory with a synchronous port. After a start pulse it runs seven pattern cases over one or more address windows. In each case it writes a generated value into every word of the window and then reads each word back and compares it. The first word that reads back wrong stops the whole run. The engine then reports the failing byte address, the value it wrote and the value it read.

Two coverage modes exist. The fast mode tests only small windows on either side of each large boundary step (1 MiB by default) inside the region, so a large memory can be screened in a short time. The slow mode treats the whole region as one window. Pattern values that depend on position use the word index counted from the start of the current window.

Top module: `mem_pattern_engine`

## Requirements
- R1: Within a window the cases run in this order: all zeros, all ones, 0x55555555, 0xAAAAAAAA, walking one, word index, inverted word index.
- R2: In the walking-one case, the word with index i receives a single set bit at position (i mod 32).
- R3: In the index case, word i receives i, and in the inverted case it receives the bitwise complement of i. The index i is the word's offset in words from the start of its window, so it restarts at 0 in every window.
- R4: Each case first writes every word of the window in ascending address order (memWe high). It then reads every word in ascending order (memWe low). Read data is taken from memRdata in the cycle after the read request. The next case starts only after all reads of the current case have been compared.
- R5: The first mismatch ends the run. The engine issues no further memory access and raises done with pass low. failAddr holds the byte address, failExp the expected value, and failGot the value returned by that single read.
- R6: In fast mode, let N be regionSize divided by the step size. For k = 0 .. N-1 in rising order, the engine tests two windows, each of half-window size (2 KiB by default). The first ends at baseAddr + k·step and is skipped for k = 0. The second starts at baseAddr + k·step. Every window gets all seven cases.
- R7: In slow mode (slowMode high at start), the engine tests the whole region as a single window of regionSize/4 words starting at baseAddr.
- R8: If there is no window to test (fast mode with regionSize below one step, or slow mode with regionSize below 4), done and pass are raised without any memory access.
- R9: A start pulse in idle clears done, pass and the three fail report outputs and starts a run. busy is high for the duration of the run. start is ignored while busy. done and pass then hold until the next accepted start.
- R10: After reset, busy, done, pass and memReq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when idle |
| slowMode | input | 1 | 1 = whole region, 0 = boundary windows |
| baseAddr | input | ADDR_W | Region start, byte address, word aligned |
| regionSize | input | ADDR_W | Region length in bytes |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Finished without mismatch |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Byte address of the access |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, valid one cycle after a read request |
| failAddr | output | ADDR_W | Address of the first mismatch |
| failExp | output | DATA_W | Value expected there |
| failGot | output | DATA_W | Value read there |

## Verification
The embedded properties take for granted three things about the inputs:
- The memory answers every read with data exactly one cycle later.
- baseAddr is word aligned.
- The tested windows do not wrap past the top of the address space.

Under these assumptions, the pattern index never runs past the window's last word, and a reported failure always carries differing expected and read values. The bench memory model has a fixed one-cycle read latency. All bases are aligned and well below the top of the address range. Faults are injected only as a stuck read bit or as an aliased write address, so every mismatch reaches the engine through the normal read path.

// File: rtl/mpe_pkg.sv
package mpe_pkg;

  // Pattern cases in the order the engine applies them
  typedef enum logic [2:0] {
    CASE_ZERO  = 3'd0,
    CASE_ONES  = 3'd1,
    CASE_FIVES = 3'd2,
    CASE_AAS   = 3'd3,
    CASE_WALK  = 3'd4,
    CASE_INDEX = 3'd5,
    CASE_NINDEX = 3'd6
  } caseSel_e;

  localparam caseSel_e LAST_CASE = CASE_NINDEX;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_DRAIN
  } ctrlState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrIdx;   // restart word index at 0
    logic wrStb;    // issue write of current word, advance index
    logic rdStb;    // issue read of current word, advance index
    logic chkEn;    // compare results are meaningful, latch first mismatch
    logic clrRpt;   // wipe failure report
  } dpCtl_t;

endpackage

// File: rtl/mpe_patgen.sv
module mpe_patgen
  import mpe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 30
) (
  input  caseSel_e            caseSel,
  input  logic [IDX_W-1:0]    idx,
  output logic [DATA_W-1:0]   pat
);

  localparam int SH_W = $clog2(DATA_W);

  always_comb begin
    pat = '0;
    unique case (caseSel)
      CASE_ZERO:   pat = '0;
      CASE_ONES:   pat = '1;
      CASE_FIVES:  pat = {(DATA_W/2){2'b01}};
      CASE_AAS:    pat = {(DATA_W/2){2'b10}};
      CASE_WALK:   pat[idx[SH_W-1:0]] = 1'b1;
      CASE_INDEX:  pat = DATA_W'(idx);
      CASE_NINDEX: pat = ~DATA_W'(idx);
      default:     pat = '0;
    endcase
  end

endmodule

// File: rtl/mpe_datapath.sv
module mpe_datapath
  import mpe_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int BYTE_LG2 = 2,
  parameter int IDX_W    = ADDR_W - BYTE_LG2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  caseSel_e          caseSel,
  input  logic [ADDR_W-1:0] winStart,
  input  logic [IDX_W-1:0]  winLast,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              isLast,
  output logic              pendBusy,
  output logic              mismatch,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failGot
);

  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] curPat;

  // read pipeline: request stage, then capture stage
  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendExp;
  logic              capValid;
  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capExp;
  logic [DATA_W-1:0] capData;

  mpe_patgen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_patgen (
    .caseSel (caseSel),
    .idx     (idx),
    .pat     (curPat)
  );

  assign memReq   = ctl.wrStb | ctl.rdStb;
  assign memWe    = ctl.wrStb;
  assign memAddr  = winStart + {idx, {BYTE_LG2{1'b0}}};
  assign memWdata = curPat;
  assign isLast   = (idx == winLast);
  assign pendBusy = pendValid;
  // compare uses only the captured word, never a second read
  assign mismatch = capValid && (capData != capExp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
    end else if (ctl.clrIdx) begin
      idx <= '0;
    end else if (ctl.wrStb || ctl.rdStb) begin
      idx <= idx + IDX_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendExp   <= '0;
      capValid  <= 1'b0;
      capAddr   <= '0;
      capExp    <= '0;
      capData   <= '0;
    end else begin
      pendValid <= ctl.rdStb;
      pendAddr  <= memAddr;
      pendExp   <= curPat;
      capValid  <= pendValid;
      capAddr   <= pendAddr;
      capExp    <= pendExp;
      capData   <= memRdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failAddr <= '0;
      failExp  <= '0;
      failGot  <= '0;
    end else if (ctl.clrRpt) begin
      failAddr <= '0;
      failExp  <= '0;
      failGot  <= '0;
    end else if (ctl.chkEn && mismatch) begin
      failAddr <= capAddr;
      failExp  <= capExp;
      failGot  <= capData;
    end
  end

  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrStb || ctl.rdStb) |-> (idx <= winLast));

  // R4
  one_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.wrStb && ctl.rdStb));

endmodule

// File: rtl/mpe_ctrl.sv
module mpe_ctrl
  import mpe_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STEP_LG2 = 20,
  parameter int WIN_LG2  = 11,
  parameter int BYTE_LG2 = 2,
  parameter int IDX_W    = ADDR_W - BYTE_LG2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              slowMode,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] regionSize,
  input  logic              isLast,
  input  logic              pendBusy,
  input  logic              mismatch,
  output dpCtl_t            ctl,
  output caseSel_e          caseSel,
  output logic [ADDR_W-1:0] winStart,
  output logic [IDX_W-1:0]  winLast,
  output logic              busy,
  output logic              done,
  output logic              pass
);

  localparam int K_W = ADDR_W - STEP_LG2 + 1;
  localparam logic [K_W-1:0]    K_ONE      = K_W'(1);
  localparam logic [ADDR_W-1:0] HALF_BYTES = ADDR_W'(1) << WIN_LG2;
  localparam logic [IDX_W-1:0]  HALF_LAST  = IDX_W'((1 << (WIN_LG2 - BYTE_LG2)) - 1);

  ctrlState_e        state;
  logic              slowQ;
  logic              sideHigh;   // 1: window starts at the boundary
  logic [ADDR_W-1:0] baseQ;
  logic [K_W-1:0]    nSteps;
  logic [K_W-1:0]    kQ;
  logic [K_W-1:0]    kNext;
  logic              lastStep;
  logic [ADDR_W-1:0] sizeWords;
  logic [K_W-1:0]    sizeSteps;

  function automatic logic [ADDR_W-1:0] boundaryAt(input logic [ADDR_W-1:0] b,
                                                   input logic [K_W-1:0] k);
    return b + (ADDR_W'(k) << STEP_LG2);
  endfunction

  assign sizeWords = regionSize >> BYTE_LG2;
  assign sizeSteps = K_W'(regionSize >> STEP_LG2);
  assign kNext     = kQ + K_ONE;
  assign lastStep  = (kNext >= nSteps);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_IDLE: begin
        ctl.clrIdx = start;
        ctl.clrRpt = start;
      end
      ST_WRITE: begin
        ctl.wrStb  = 1'b1;
        ctl.clrIdx = isLast;
      end
      ST_READ: begin
        ctl.rdStb  = 1'b1;
        ctl.chkEn  = 1'b1;
        ctl.clrIdx = isLast;
      end
      ST_DRAIN: begin
        ctl.chkEn  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      caseSel  <= CASE_ZERO;
      slowQ    <= 1'b0;
      sideHigh <= 1'b0;
      baseQ    <= '0;
      nSteps   <= '0;
      kQ       <= '0;
      winStart <= '0;
      winLast  <= '0;
      done     <= 1'b0;
      pass     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            slowQ    <= slowMode;
            baseQ    <= baseAddr;
            caseSel  <= CASE_ZERO;
            kQ       <= '0;
            sideHigh <= 1'b1;
            winStart <= baseAddr;
            nSteps   <= sizeSteps;
            done     <= 1'b0;
            pass     <= 1'b0;
            if (slowMode) begin
              winLast <= IDX_W'(sizeWords - ADDR_W'(1));
              if (sizeWords == '0) begin
                done <= 1'b1;
                pass <= 1'b1;
              end else begin
                state <= ST_WRITE;
              end
            end else begin
              winLast <= HALF_LAST;
              if (sizeSteps == '0) begin
                done <= 1'b1;
                pass <= 1'b1;
              end else begin
                state <= ST_WRITE;
              end
            end
          end
        end
        ST_WRITE: begin
          if (isLast) state <= ST_READ;
        end
        ST_READ: begin
          if (mismatch) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            pass  <= 1'b0;
          end else if (isLast) begin
            state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (mismatch) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            pass  <= 1'b0;
          end else if (!pendBusy) begin
            if (caseSel != LAST_CASE) begin
              caseSel <= caseSel_e'(caseSel + 3'd1);
              state   <= ST_WRITE;
            end else begin
              caseSel <= CASE_ZERO;
              if (slowQ || (sideHigh && lastStep)) begin
                state <= ST_IDLE;
                done  <= 1'b1;
                pass  <= 1'b1;
              end else if (!sideHigh) begin
                sideHigh <= 1'b1;
                winStart <= boundaryAt(baseQ, kQ);
                state    <= ST_WRITE;
              end else begin
                kQ       <= kNext;
                sideHigh <= 1'b0;
                winStart <= boundaryAt(baseQ, kNext) - HALF_BYTES;
                state    <= ST_WRITE;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  case_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (caseSel != $past(caseSel)) |->
      ((caseSel == caseSel_e'($past(caseSel) + 3'd1)) || (caseSel == CASE_ZERO)));

  // R9
  busy_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

  // R8
  pass_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> done);

  // R6
  win_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (winStart != $past(winStart))) |-> (caseSel == CASE_ZERO));

endmodule

// File: rtl/mem_pattern_engine.sv
module mem_pattern_engine
  import mpe_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int STEP_LG2 = 20,
  parameter int WIN_LG2  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              slowMode,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] regionSize,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failGot
);

  localparam int BYTE_LG2 = $clog2(DATA_W / 8);
  localparam int IDX_W    = ADDR_W - BYTE_LG2;

  dpCtl_t            ctl;
  caseSel_e          caseSel;
  logic [ADDR_W-1:0] winStart;
  logic [IDX_W-1:0]  winLast;
  logic              isLast;
  logic              pendBusy;
  logic              mismatch;

  mpe_ctrl #(
    .ADDR_W(ADDR_W), .STEP_LG2(STEP_LG2), .WIN_LG2(WIN_LG2),
    .BYTE_LG2(BYTE_LG2), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .slowMode(slowMode),
    .baseAddr(baseAddr), .regionSize(regionSize),
    .isLast(isLast), .pendBusy(pendBusy), .mismatch(mismatch),
    .ctl(ctl), .caseSel(caseSel), .winStart(winStart), .winLast(winLast),
    .busy(busy), .done(done), .pass(pass)
  );

  mpe_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_LG2(BYTE_LG2), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .caseSel(caseSel),
    .winStart(winStart), .winLast(winLast),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .isLast(isLast), .pendBusy(pendBusy),
    .mismatch(mismatch), .failAddr(failAddr), .failExp(failExp), .failGot(failGot)
  );

  // R5
  fail_rpt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !pass) |-> (failExp != failGot));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

endmodule

// File: tb/mem_pattern_engine_tb.sv
`timescale 1ns/1ps
module mem_pattern_engine_tb;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int STEP_LG2 = 10;   // 1 KiB step in the bench
  localparam int WIN_LG2  = 6;    // 64-byte windows
  localparam int STEP = 1 << STEP_LG2;
  localparam int HALF = 1 << WIN_LG2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic slowMode = 1'b0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic [ADDR_W-1:0] regionSize = '0;
  logic busy, done, pass, memReq, memWe;
  logic [ADDR_W-1:0] memAddr, failAddr;
  logic [DATA_W-1:0] memWdata, failExp, failGot;
  logic [DATA_W-1:0] memRdata = '0;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  mem_pattern_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_LG2(STEP_LG2), .WIN_LG2(WIN_LG2)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .slowMode(slowMode),
    .baseAddr(baseAddr), .regionSize(regionSize),
    .busy(busy), .done(done), .pass(pass),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .failAddr(failAddr), .failExp(failExp), .failGot(failGot)
  );

  // memory model with fault injection
  logic [31:0] mem [int unsigned];
  logic [31:0] wAddrQ[$];
  logic [31:0] wDataQ[$];
  logic [31:0] expA[$];
  logic [31:0] expD[$];
  int readCnt = 0;
  bit stuckOn = 0;
  logic [31:0] stuckAddr = 0, stuckMask = 0;
  bit aliasOn = 0;
  logic [31:0] aliasSrc = 0, aliasDst = 0;

  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) begin
        mem[memAddr] = memWdata;
        if (aliasOn && memAddr == aliasSrc) mem[aliasDst] = memWdata;
        wAddrQ.push_back(memAddr);
        wDataQ.push_back(memWdata);
      end else begin
        logic [31:0] rd;
        rd = mem.exists(memAddr) ? mem[memAddr] : 32'h0;
        if (stuckOn && memAddr == stuckAddr) rd = rd | stuckMask;
        memRdata <= rd;
        readCnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expPat(input int c, input int unsigned i);
    case (c)
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h5555_5555;
      3: return 32'hAAAA_AAAA;
      4: return 32'h1 << (i % 32);
      5: return i;
      default: return ~i;
    endcase
  endfunction

  task automatic addWindow(input logic [31:0] ws, input int words);
    for (int c = 0; c < 7; c++)
      for (int i = 0; i < words; i++) begin
        expA.push_back(ws + 32'(i * 4));
        expD.push_back(expPat(c, i));
      end
  endtask

  task automatic buildExpected(input bit slow, input logic [31:0] b, input logic [31:0] sz);
    expA.delete(); expD.delete();
    if (slow) begin
      if (sz >= 4) addWindow(b, int'(sz / 4));
    end else begin
      for (int k = 0; k < int'(sz >> STEP_LG2); k++) begin
        if (k > 0) addWindow(b + 32'(k * STEP) - 32'(HALF), HALF / 4);
        addWindow(b + 32'(k * STEP), HALF / 4);
      end
    end
  endtask

  task automatic compareStream(input string req);
    int nb = 0;
    int firstBad = -1;
    if (wAddrQ.size() == expA.size()) begin
      foreach (expA[n])
        if (wAddrQ[n] !== expA[n] || wDataQ[n] !== expD[n]) begin
          nb++;
          if (firstBad < 0) firstBad = n;
        end
    end else nb = 1;
    if (firstBad >= 0)
      check(0, req, {wAddrQ[firstBad], wDataQ[firstBad]}, {expA[firstBad], expD[firstBad]});
    else
      check(nb == 0, req, 64'(wAddrQ.size()), 64'(expA.size()));
  endtask

  task automatic resetModel();
    mem.delete(); wAddrQ.delete(); wDataQ.delete();
    readCnt = 0; stuckOn = 0; aliasOn = 0;
  endtask

  task automatic runAndWait(input bit slow, input logic [31:0] b, input logic [31:0] sz,
                            input int extraStartAt);
    int cyc = 0;
    @(negedge clk);
    slowMode = slow; baseAddr = b; regionSize = sz; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (cyc == extraStartAt) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    check(done === 1'b1, "R9 watchdog wait for done", 64'(done), 64'd1);
  endtask

  task automatic tReset();
    check(busy === 0 && done === 0 && pass === 0 && memReq === 0,
          "R10 reset state", {busy, done, pass, memReq}, 4'b0000);
  endtask

  task automatic tSlowClean();
    resetModel();
    buildExpected(1, 32'h1000, 32'd64);
    runAndWait(1, 32'h1000, 32'd64, 0);
    check(pass === 1, "R7 slow pass", 64'(pass), 1);
    compareStream("R1 R2 R3 R4 R7 slow write stream");
    check(readCnt == 7 * 16, "R4 read count", 64'(readCnt), 112);
    for (int i = 0; i < 16; i++)
      check(mem[32'h1000 + 32'(i * 4)] === ~32'(i), "R3 final inverted index",
            64'(mem[32'h1000 + 32'(i * 4)]), 64'(~32'(i)));
    repeat (10) @(negedge clk);
    check(done === 1 && pass === 1, "R9 done and pass hold", {done, pass}, 2'b11);
  endtask

  task automatic tFastWindows();
    resetModel();
    buildExpected(0, 32'h2_0000, 32'(3 * STEP + 100));
    runAndWait(0, 32'h2_0000, 32'(3 * STEP + 100), 0);
    check(pass === 1, "R6 fast pass", 64'(pass), 1);
    compareStream("R6 R3 fast window stream");
    check(wAddrQ.size() == 5 * 7 * 16, "R6 window count", 64'(wAddrQ.size()), 560);
  endtask

  task automatic tNoWindow();
    resetModel();
    runAndWait(0, 32'h3000, 32'(STEP - 4), 0);
    check(pass === 1 && wAddrQ.size() == 0 && readCnt == 0, "R8 fast no window",
          64'(wAddrQ.size() + readCnt), 0);
    runAndWait(1, 32'h3000, 32'd2, 0);
    check(pass === 1 && wAddrQ.size() == 0 && readCnt == 0, "R8 slow no window",
          64'(wAddrQ.size() + readCnt), 0);
  endtask

  task automatic tStuckBit();
    int acc;
    resetModel();
    stuckOn = 1; stuckAddr = 32'h4000 + 20; stuckMask = 32'h1;
    runAndWait(1, 32'h4000, 32'd64, 0);
    check(pass === 0, "R5 stuck fails", 64'(pass), 0);
    check(failAddr === 32'h4014, "R5 fail address", 64'(failAddr), 64'h4014);
    check(failExp === 32'h0 && failGot === 32'h1, "R5 exp and got",
          {failExp, failGot}, {32'h0, 32'h1});
    check(wAddrQ.size() == 16, "R5 run stops after first case", 64'(wAddrQ.size()), 16);
    acc = wAddrQ.size() + readCnt;
    repeat (20) @(negedge clk);
    check(wAddrQ.size() + readCnt == acc, "R5 no access after failure",
          64'(wAddrQ.size() + readCnt), 64'(acc));
  endtask

  task automatic tAlias();
    resetModel();
    aliasOn = 1; aliasSrc = 32'h8000 + 20; aliasDst = 32'h8000 + 16;
    runAndWait(1, 32'h8000, 32'd64, 0);
    check(pass === 0 && failAddr === 32'h8010, "R2 alias caught by walking one",
          64'(failAddr), 64'h8010);
    check(failExp === 32'h10 && failGot === 32'h20, "R2 walking exp and got",
          {failExp, failGot}, {32'h10, 32'h20});
    check(wAddrQ.size() == 80, "R1 constants pass before walking case",
          64'(wAddrQ.size()), 80);
  endtask

  task automatic tRestartIgnore();
    resetModel();
    buildExpected(1, 32'h100, 32'd128);
    runAndWait(1, 32'h100, 32'd128, 50);
    check(pass === 1, "R9 restart after failure passes", 64'(pass), 1);
    check(failAddr === 0 && failExp === 0 && failGot === 0, "R9 report cleared",
          {failAddr, failExp}, 64'h0);
    compareStream("R9 start while busy ignored");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSlowClean();
    tFastWindows();
    tNoWindow();
    tStuckBit();
    tAlias();
    tRestartIgnore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule